// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, keeps track of which ones are waiting, and raises one interrupt output toward a processor when a request should be served. It holds three 8-bit registers: a pending register that records requests, a mask register that takes individual lines out of contention, and an in-service register with one bit for each level the processor is working on. A priority resolver compares them and asserts the interrupt output only for an unmasked pending level whose priority is above every in-service level.

The processor answers with a one-cycle active-low acknowledge. The controller then moves the winning level from pending to in-service, drops the interrupt output, and returns a vector byte made of a programmable 5-bit base and the 3-bit level number. A small register port, selected by chip select and one address bit, lets software set masks, choose edge or level triggering, choose fixed or rotating priority, load the vector base, issue end-of-interrupt, and poll for the winning level instead of taking an interrupt.

All inputs are sampled on the rising clock edge. Register reads and acknowledge return their byte on `dout` one cycle after the strobe, and the byte is held until the next read or accepted acknowledge.

Top module: `prio_intc`

## Requirements
- R1: After reset the interrupt output is low, `dout` is 0x00, the mask register is 0xFF, pending and in-service registers are clear, edge triggering and fixed priority are selected and the vector base is 0.
- R2: In edge mode a line becomes pending on a low-to-high transition; a line held high after its acknowledge is not latched again until it has gone low and risen once more.
- R3: In level mode a pending bit follows its input, so a request that drops before acknowledge is forgotten and a line still high after acknowledge shows as pending again.
- R4: A set mask bit keeps its line out of priority resolution while its pending bit is still recorded and readable.
- R5: In fixed priority line 0 has the highest priority and line 7 the lowest.
- R6: A one-cycle low on `inta_n` while `int_out` is high returns {base, level} on `dout` in the next cycle, clears that pending bit, sets its in-service bit and leaves `int_out` low in that cycle; an acknowledge while `int_out` is low changes nothing.
- R7: A pending level is forwarded only when its priority is above every in-service level, so equal and lower levels wait while a higher one nests.
- R8: An end-of-interrupt command clears only the highest-priority set in-service bit.
- R9: In rotating mode the level cleared by an end-of-interrupt becomes the lowest priority and the level after it the highest.
- R10: A poll command makes the next command-port read return 0x80 | level for the level that would be forwarded, taking that level into service; with nothing forwardable it returns 0x00.
- R11: With chip select low, a write with `a0`=1 loads the mask and a read with `a0`=1 returns it; a write with `a0`=0 is a command decoded on `din`: bit 7 set loads the base from bits 4..0; otherwise bits 7..5 = 000 sets the mode (bit 0 level trigger, bit 1 rotating), 001 is end-of-interrupt, 010 arms a poll; a read with `a0`=0 returns the pending register when no poll is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select for the register port |
| wr_n | input | 1 | Active-low write strobe, one cycle per access |
| rd_n | input | 1 | Active-low read strobe, one cycle per access |
| a0 | input | 1 | Register select: 0 command/pending, 1 mask |
| din | input | 8 | Write data |
| dout | output | 8 | Read data and acknowledge vector |
| irq | input | 8 | Interrupt request lines 0 to 7 |
| int_out | output | 1 | Interrupt request toward the processor |
| inta_n | input | 1 | Active-low interrupt acknowledge, one cycle |

## Verification
The embedded properties assume the request lines and all port strobes are synchronous to `clk`, that a read and a write never share a cycle, and that each acknowledge or access strobe lasts exactly one cycle. They also take for granted that the processor acknowledges only after seeing `int_out`. The directed bench respects this by changing every input on the falling edge, pulsing each strobe for a single cycle through one task per access, and acknowledging only after `int_out` has been confirmed high; the one deliberate stray acknowledge is issued with nothing pending.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned NLINES = 8;
  localparam int unsigned LVLW   = $clog2(NLINES);
  localparam int unsigned DATAW  = 8;
  localparam int unsigned BASEW  = DATAW - LVLW;

  typedef enum logic [2:0] {
    OP_MODE = 3'b000,
    OP_EOI  = 3'b001,
    OP_POLL = 3'b010
  } cmd_op_e;
endpackage

// File: rtl/prio_intc_req_latch.sv
module prio_intc_req_latch #(
  parameter int unsigned N = prio_intc_pkg::NLINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level_mode,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic pend_d;
    logic rise;

    always_comb begin
      rise = irq[i] & ~prev_q[i];
      if (level_mode) pend_d = irq[i] & ~clr[i];
      else            pend_d = (pend_q[i] | rise) & ~clr[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= irq[i];
        pend_q[i] <= pend_d;
      end
    end

    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && !pend_q[i] && !(irq[i] && !prev_q[i])) |=> !pend_q[i]);
  end

  assign pend = pend_q;
endmodule

// File: rtl/prio_intc_resolver.sv
module prio_intc_resolver #(
  parameter int unsigned N  = prio_intc_pkg::NLINES,
  parameter int unsigned LW = prio_intc_pkg::LVLW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] lowest,
  output logic          valid,
  output logic [LW-1:0] level,
  output logic [LW-1:0] rank
);
  logic [LW-1:0] idx;

  // rank 0 is the line just after the lowest-priority one
  always_comb begin
    valid = 1'b0;
    level = '0;
    rank  = '0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = lowest + LW'(1) + LW'(k);
      if (vec[idx]) begin
        valid = 1'b1;
        level = idx;
        rank  = LW'(k);
      end
    end
  end

  // R5
  sel_in_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> vec[level]);

  // R5
  sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (vec == '0));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             a0,
  input  logic [DATAW-1:0] din,
  output logic [DATAW-1:0] dout,
  input  logic [NLINES-1:0] irq,
  output logic             int_out,
  input  logic             inta_n
);
  localparam int unsigned PADW = DATAW - 1 - LVLW;

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_s1_q, rst_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_s1_q <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n    <= rst_s1_q;
    end
  end

  logic [NLINES-1:0] mask_q, mask_d, isr_q, isr_d, pend;
  logic [NLINES-1:0] take_vec, clr_isr;
  logic [BASEW-1:0]  base_q, base_d;
  logic [LVLW-1:0]   lo_q, lo_d, eff_lo;
  logic              lvl_q, lvl_d, rot_q, rot_d, poll_q, poll_d, int_q, int_d;
  logic [DATAW-1:0]  dout_q, dout_d;

  logic wr_cmd, wr_msk, rd_cmd, rd_msk, mode_wr, base_wr, eoi, poll_arm;
  logic fwd, ack_take, poll_take, take;
  logic rq_valid, is_valid;
  logic [LVLW-1:0] rq_level, rq_rank, is_level, is_rank;
  cmd_op_e op;

  always_comb begin
    wr_cmd   = !cs_n && !wr_n && !a0;
    wr_msk   = !cs_n && !wr_n &&  a0;
    rd_cmd   = !cs_n && !rd_n && !a0;
    rd_msk   = !cs_n && !rd_n &&  a0;
    op       = cmd_op_e'(din[7:5]);
    base_wr  = wr_cmd &&  din[7];
    mode_wr  = wr_cmd && !din[7] && (op == OP_MODE);
    eoi      = wr_cmd && !din[7] && (op == OP_EOI);
    poll_arm = wr_cmd && !din[7] && (op == OP_POLL);
    eff_lo   = rot_q ? lo_q : LVLW'(NLINES - 1);
  end

  prio_intc_req_latch #(.N(NLINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .level_mode(lvl_q),
    .irq(irq), .clr(take_vec), .pend(pend)
  );

  prio_intc_resolver #(.N(NLINES), .LW(LVLW)) u_req_res (
    .clk(clk), .rst_n(rst_n), .vec(pend & ~mask_q), .lowest(eff_lo),
    .valid(rq_valid), .level(rq_level), .rank(rq_rank)
  );

  prio_intc_resolver #(.N(NLINES), .LW(LVLW)) u_isr_res (
    .clk(clk), .rst_n(rst_n), .vec(isr_q), .lowest(eff_lo),
    .valid(is_valid), .level(is_level), .rank(is_rank)
  );

  always_comb begin
    fwd       = rq_valid && (!is_valid || (rq_rank < is_rank));
    ack_take  = !inta_n && int_q && fwd;
    poll_take = rd_cmd && poll_q && fwd;
    take      = ack_take || poll_take;
    take_vec  = take ? (NLINES'(1) << rq_level) : '0;
    clr_isr   = (eoi && is_valid) ? (NLINES'(1) << is_level) : '0;

    isr_d  = (isr_q & ~clr_isr) | take_vec;
    mask_d = wr_msk  ? din        : mask_q;
    base_d = base_wr ? din[BASEW-1:0] : base_q;
    lvl_d  = mode_wr ? din[0]     : lvl_q;
    rot_d  = mode_wr ? din[1]     : rot_q;
    lo_d   = (eoi && is_valid && rot_q) ? is_level : lo_q;
    poll_d = poll_arm ? 1'b1 : (rd_cmd ? 1'b0 : poll_q);
    int_d  = fwd && !take;

    dout_d = dout_q;
    if (ack_take)    dout_d = {base_q, rq_level};
    else if (rd_msk) dout_d = mask_q;
    else if (rd_cmd) dout_d = poll_q ? {fwd, {PADW{1'b0}}, (fwd ? rq_level : LVLW'(0))}
                                     : pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      isr_q  <= '0;
      base_q <= '0;
      lo_q   <= LVLW'(NLINES - 1);
      lvl_q  <= 1'b0;
      rot_q  <= 1'b0;
      poll_q <= 1'b0;
      int_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      mask_q <= mask_d;
      isr_q  <= isr_d;
      base_q <= base_d;
      lo_q   <= lo_d;
      lvl_q  <= lvl_d;
      rot_q  <= rot_d;
      poll_q <= poll_d;
      int_q  <= int_d;
      dout_q <= dout_d;
    end
  end

  assign int_out = int_q;
  assign dout    = dout_q;

  // R6
  ack_drops_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !int_out);

  // R6
  ack_isr_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !eoi) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  // R8
  eoi_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !take && (isr_q != '0)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

  // R4
  masked_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !$past(mask_q[rq_level]));
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       arst_n, cs_n, wr_n, rd_n, a0, inta_n;
  logic [7:0] din, dout, irq;
  logic       int_out;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .a0(a0), .din(din), .dout(dout), .irq(irq), .int_out(int_out),
    .inta_n(inta_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq = v;
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; a0 = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; a0 = a;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    v = dout;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk);
    inta_n = 1'b0;
    @(negedge clk);
    inta_n = 1'b1;
    v = dout;
  endtask

  task automatic eoi();
    do_wr(1'b0, 8'h20);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 int_out", {7'b0, int_out}, 8'h00);
    check("R1 dout", dout, 8'h00);
    do_rd(1'b1, v); check("R1 R11 mask reset", v, 8'hFF);
    do_rd(1'b0, v); check("R1 pending reset", v, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    do_wr(1'b1, 8'h00);
    do_wr(1'b0, 8'h95);
    set_irq(8'h0C); idle(3);
    check("R5 int raised", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R5 R6 vector line2", v, 8'hAA);
    check("R6 int dropped", {7'b0, int_out}, 8'h00);
    idle(3); check("R7 equal/lower blocked", {7'b0, int_out}, 8'h00);
    do_rd(1'b0, v); check("R2 R11 pending after ack", v, 8'h08);
    eoi(); idle(3);
    check("R8 line3 after eoi", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R6 vector line3", v, 8'hAB);
    eoi(); idle(3);
    check("R2 held lines not relatched", {7'b0, int_out}, 8'h00);
    do_rd(1'b0, v); check("R2 pending empty", v, 8'h00);
    set_irq(8'h00); idle(2);
    set_irq(8'h04); idle(3);
    check("R2 new rise latched", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R2 vector line2 again", v, 8'hAA);
    eoi(); set_irq(8'h00); idle(2);
  endtask

  task automatic t_nest();
    logic [7:0] v;
    set_irq(8'h20); idle(3);
    do_ack(v); check("R6 vector line5", v, 8'hAD);
    set_irq(8'h22); idle(3);
    check("R7 higher nests", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R7 vector line1", v, 8'hA9);
    set_irq(8'h62); idle(3);
    check("R7 lower blocked", {7'b0, int_out}, 8'h00);
    eoi(); idle(3);
    check("R7 line6 below line5", {7'b0, int_out}, 8'h00);
    set_irq(8'h6A); idle(3);
    check("R8 eoi cleared line1 only", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R8 vector line3", v, 8'hAB);
    eoi(); idle(3);
    check("R8 line5 still blocks", {7'b0, int_out}, 8'h00);
    eoi(); idle(3);
    check("R8 line6 released", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R6 vector line6", v, 8'hAE);
    eoi(); set_irq(8'h00); idle(2);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    do_wr(1'b1, 8'h01);
    set_irq(8'h11); idle(3);
    check("R4 int for unmasked", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R4 masked line0 skipped", v, 8'hAC);
    do_rd(1'b0, v); check("R4 masked still pending", v, 8'h01);
    do_wr(1'b1, 8'h00); idle(3);
    check("R4 unmasked interrupts", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R4 vector line0", v, 8'hA8);
    eoi(); eoi(); set_irq(8'h00); idle(2);
  endtask

  task automatic t_level();
    logic [7:0] v;
    do_wr(1'b0, 8'h01);
    set_irq(8'h40); idle(2);
    do_rd(1'b0, v); check("R3 level pending", v, 8'h40);
    set_irq(8'h00); idle(2);
    do_rd(1'b0, v); check("R3 dropped forgotten", v, 8'h00);
    check("R3 no int after drop", {7'b0, int_out}, 8'h00);
    set_irq(8'h40); idle(3);
    do_ack(v); check("R3 vector line6", v, 8'hAE);
    idle(1);
    do_rd(1'b0, v); check("R3 still high repends", v, 8'h40);
    check("R7 repended blocked", {7'b0, int_out}, 8'h00);
    eoi(); idle(3);
    check("R3 level reinterrupts", {7'b0, int_out}, 8'h01);
    do_ack(v);
    set_irq(8'h00); eoi(); idle(2);
    check("R3 idle after drop", {7'b0, int_out}, 8'h00);
    do_wr(1'b0, 8'h00);
  endtask

  task automatic t_rotate();
    logic [7:0] v;
    do_wr(1'b0, 8'h02);
    set_irq(8'h03); idle(3);
    do_ack(v); check("R9 first line0", v, 8'hA8);
    eoi();
    set_irq(8'h02); set_irq(8'h03); idle(3);
    do_ack(v); check("R9 line1 beats line0", v, 8'hA9);
    idle(3);
    check("R9 line0 lowest blocked", {7'b0, int_out}, 8'h00);
    eoi(); idle(3);
    check("R9 line0 after eoi", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R9 vector line0", v, 8'hA8);
    eoi(); set_irq(8'h00); idle(2);
    do_wr(1'b0, 8'h00);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    do_wr(1'b0, 8'h40);
    do_rd(1'b0, v); check("R10 poll empty", v, 8'h00);
    set_irq(8'h20); idle(3);
    do_wr(1'b0, 8'h40);
    do_rd(1'b0, v); check("R10 poll line5", v, 8'h85);
    idle(3); check("R10 polled in service", {7'b0, int_out}, 8'h00);
    do_rd(1'b0, v); check("R10 R11 plain read pending", v, 8'h00);
    eoi(); set_irq(8'h00); idle(2);
  endtask

  task automatic t_stray_ack();
    logic [7:0] v;
    do_wr(1'b1, 8'h5A);
    do_rd(1'b1, v); check("R11 mask readback", v, 8'h5A);
    do_ack(v); check("R6 stray ack ignored", v, 8'h5A);
    check("R6 stray ack no int", {7'b0, int_out}, 8'h00);
  endtask

  initial begin
    arst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; a0 = 1'b0;
    din = 8'h00; irq = 8'h00; inta_n = 1'b1;
    idle(3);
    arst_n = 1'b1;
    idle(3);
    t_reset();
    t_edge();
    t_nest();
    t_mask();
    t_level();
    t_rotate();
    t_poll();
    t_stray_ack();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule